// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Burst Order

This block models a synchronous static memory built for back-to-back traffic. Address and control are sampled on each rising clock edge while the clock enable is low and the three chip selects are all active. The data that belongs to that access moves one clock later. Read data is registered and comes out after the next enabled edge. Write data is captured at that same next enabled edge. Because both directions use the same lag, a read can follow a write with no idle cycle between them.

A load cycle (advance low) starts an access at the presented address. It latches the direction and the burst order. An advance cycle (advance high) moves the two low address bits to the next burst position, in either linear or interleaved order. The upper bits, the direction and the order all stay as latched at the last load.

Each word holds 32 data bits and 4 parity bits, one parity bit per byte. Each byte lane, together with its parity bit, has its own write enable. The address port is 17 bits wide. The storage holds 2^STORE_AW words and is indexed by the low STORE_AW address bits, so upper address bits alias.

Top module: `zt_burst_sram`

## Requirements
- R1: An access is issued only on an edge where en_n is low, sel1_n is low, sel2 is high and sel3_n is low. On any other enabled edge nothing is issued: rvalid is low after the following enabled edge, and the stored words are unchanged.
- R2: When adv is low on an issuing edge, the access targets addr. It latches the direction (wr_n low means write, high means read) and the order (order_sel 0 means linear, 1 means interleaved).
- R3: In linear order, the low two address bits of the k-th access after a load are (start + k) mod 4. The sequences are: start 0 gives 0,1,2,3; start 1 gives 1,2,3,0; start 2 gives 2,3,0,1; start 3 gives 3,0,1,2.
- R4: In interleaved order, the low two address bits of the k-th access after a load are start XOR k. The sequences are: start 0 gives 0,1,2,3; start 1 gives 1,0,3,2; start 2 gives 2,3,0,1; start 3 gives 3,2,1,0.
- R5: After the fourth burst address, continued advancing repeats the same four-address sequence.
- R6: During advance cycles, wr_n and order_sel are ignored. The upper address bits, the direction and the order all come from the last load.
- R7: A read issued at one enabled edge sets rvalid high and drives the word on rdata after the next enabled edge. rdata holds its last read value otherwise. rvalid is low after an edge whose previous issue was a write or nothing.
- R8: A write stores wdata sampled at the enabled edge after the issuing edge. Byte k is wdata[8k+7:8k] plus parity bit wdata[32+k]. A byte and its parity bit are written only when bw_n[k] was low on the issuing edge.
- R9: A read issued on the edge right after a write to the same address returns the newly written word.
- R10: While en_n is high, the block samples no input. The burst counter, the pending access, any pending write, rdata and rvalid all hold.
- R11: A synchronous low rst_n clears rvalid, rdata, the pending access and the burst state. Stored words are not cleared.
- R12: An advance on a deselected edge does not move the burst counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Direction on load: low write, high read |
| adv | input | 1 | High advances the burst, low loads a new address |
| order_sel | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| addr | input | 17 | Word address |
| bw_n | input | 4 | Per-byte write enables, active low |
| wdata | input | 36 | Write word: parity in [35:32], data in [31:0] |
| rdata | output | 36 | Read word, same layout as wdata |
| rvalid | output | 1 | rdata carries a fresh read result |

## Verification
The hardest case to reach is a stall that lands inside a burst or between a write's control edge and its data edge. Only there does the freeze of the counter and of the pending write show. The stimulus interleaves en_n high cycles and deselected advance cycles into a running burst. It also stalls the clock enable between a write command and its data, and then checks which burst address and which word come out. A table walks all eight start/order pairs through seven accesses each. During the advances it flips order_sel and wr_n, so that a block which did not latch them at load would return the wrong words.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

  localparam int BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // low address bits of the burst position cnt counted from start
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input order_e             ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ cnt;
    return BURST_W'(start + cnt);
  endfunction

  // all three chip selects active
  function automatic logic chip_on(input logic s1_n, input logic s2, input logic s3_n);
    return ~s1_n & s2 & ~s3_n;
  endfunction

endpackage

// File: rtl/zbs_burst.sv
module zbs_burst
  import zbs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              wr_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              issue,
  output logic              iss_wr,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              load_fire,
  output logic              adv_fire
);

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic               wr_q;
  order_e             ord_q;

  assign load_fire = step_en & sel_ok & ~adv;
  assign adv_fire  = step_en & sel_ok & adv;
  assign issue     = load_fire | adv_fire;
  assign cnt_nx    = BURST_W'(cnt_q + 1'b1);

  always_comb begin
    if (load_fire) begin
      iss_addr = addr;
      iss_wr   = ~wr_n;
    end else begin
      iss_addr = {base_q[ADDR_W-1:BURST_W], burst_lo(base_q[BURST_W-1:0], cnt_nx, ord_q)};
      iss_wr   = wr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      ord_q  <= ORD_LINEAR;
    end else if (load_fire) begin
      base_q <= addr;
      cnt_q  <= '0;
      wr_q   <= ~wr_n;
      ord_q  <= order_e'(order_sel);
    end else if (adv_fire) begin
      cnt_q  <= cnt_nx;
    end
  end

endmodule

// File: rtl/zbs_pipe.sv
module zbs_pipe #(
  parameter int STORE_AW = 8,
  parameter int BYTES    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                issue,
  input  logic                iss_wr,
  input  logic [STORE_AW-1:0] iss_idx,
  input  logic [BYTES-1:0]    iss_ben,
  output logic                s1_vld,
  output logic                s1_wr,
  output logic [STORE_AW-1:0] s1_idx,
  output logic [BYTES-1:0]    s1_ben,
  output logic                wr_commit,
  output logic                rd_commit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_wr  <= 1'b0;
      s1_idx <= '0;
      s1_ben <= '0;
    end else if (step_en) begin
      s1_vld <= issue;
      s1_wr  <= iss_wr;
      s1_idx <= iss_idx;
      s1_ben <= iss_ben;
    end
  end

  assign wr_commit = rst_n & step_en & s1_vld & s1_wr;
  assign rd_commit = rst_n & step_en & s1_vld & ~s1_wr;

endmodule

// File: rtl/zbs_array.sv
module zbs_array #(
  parameter int STORE_AW = 8,
  parameter int BYTES    = 4,
  parameter int BYTE_W   = 8,
  localparam int DW      = BYTES * BYTE_W,
  localparam int WORD_W  = BYTES * (BYTE_W + 1),
  localparam int DEPTH   = 1 << STORE_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                wr_commit,
  input  logic                rd_commit,
  input  logic [STORE_AW-1:0] idx,
  input  logic [BYTES-1:0]    ben,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                rvalid
);

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [BYTE_W:0] lane_mem [DEPTH];
    logic [BYTE_W:0] lane_in;
    logic [BYTE_W:0] lane_q;

    assign lane_in = {wdata[DW+k], wdata[k*BYTE_W +: BYTE_W]};

    always_ff @(posedge clk) begin
      if (wr_commit && ben[k]) lane_mem[idx] <= lane_in;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         lane_q <= '0;
      else if (rd_commit) lane_q <= lane_mem[idx];
    end

    assign rdata[k*BYTE_W +: BYTE_W] = lane_q[BYTE_W-1:0];
    assign rdata[DW+k]               = lane_q[BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rvalid <= 1'b0;
    else if (step_en) rvalid <= rd_commit;
  end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zbs_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int STORE_AW = 8,
  parameter int BYTES    = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = BYTES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  bw_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic                step_en;
  logic                sel_ok;
  logic                issue;
  logic                iss_wr;
  logic                iss_rd;
  logic [ADDR_W-1:0]   iss_addr;
  logic                load_fire;
  logic                adv_fire;
  logic                s1_vld;
  logic                s1_wr;
  logic                s1_rd;
  logic [STORE_AW-1:0] s1_idx;
  logic [BYTES-1:0]    s1_ben;
  logic                wr_commit;
  logic                rd_commit;

  assign step_en = ~en_n;
  assign sel_ok  = chip_on(sel1_n, sel2, sel3_n);
  assign iss_rd  = issue & ~iss_wr;
  assign s1_rd   = s1_vld & ~s1_wr;

  zbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .sel_ok    (sel_ok),
    .adv       (adv),
    .wr_n      (wr_n),
    .order_sel (order_sel),
    .addr      (addr),
    .issue     (issue),
    .iss_wr    (iss_wr),
    .iss_addr  (iss_addr),
    .load_fire (load_fire),
    .adv_fire  (adv_fire)
  );

  zbs_pipe #(.STORE_AW(STORE_AW), .BYTES(BYTES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .issue     (issue),
    .iss_wr    (iss_wr),
    .iss_idx   (iss_addr[STORE_AW-1:0]),
    .iss_ben   (~bw_n),
    .s1_vld    (s1_vld),
    .s1_wr     (s1_wr),
    .s1_idx    (s1_idx),
    .s1_ben    (s1_ben),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit)
  );

  zbs_array #(.STORE_AW(STORE_AW), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit),
    .idx       (s1_idx),
    .ben       (s1_ben),
    .wdata     (wdata),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

endmodule

// File: rtl/zbs_chk.sv
module zbs_chk #(
  parameter int ADDR_W = 17,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              sel_ok,
  input logic [ADDR_W-1:0] addr,
  input logic              load_fire,
  input logic              adv_fire,
  input logic              iss_rd,
  input logic [ADDR_W-1:0] iss_addr,
  input logic              s1_rd,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid
);

  logic [ADDR_W-3:0] ld_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ld_hi_q <= '0;
    else if (load_fire) ld_hi_q <= addr[ADDR_W-1:2];
  end

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> ($stable(rdata) && $stable(rvalid)));

  // R1
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_n && !sel_ok) ##1 !en_n) |=> !rvalid);

  // R7
  rd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_rd |=> s1_rd);

  // R7
  rd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && s1_rd) |=> rvalid);

  // R6
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |-> (iss_addr[ADDR_W-1:2] == ld_hi_q));

endmodule

bind zt_burst_sram zbs_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_n      (en_n),
  .sel_ok    (sel_ok),
  .addr      (addr),
  .load_fire (load_fire),
  .adv_fire  (adv_fire),
  .iss_rd    (iss_rd),
  .iss_addr  (iss_addr),
  .s1_rd     (s1_rd),
  .rdata     (rdata),
  .rvalid    (rvalid)
);

// File: tb/sim_zt_burst_sram.sv
module sim_zt_burst_sram;
  localparam int AW = 17;
  localparam int WW = 36;

  // {order, start[1:0], expected low-bit sequence as four 2-bit slots, first slot in [7:6]}
  localparam logic [10:0] BURSTS [8] = '{
    {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h6C}, {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hC6},
    {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h4E}, {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hE4}
  };

  localparam logic [AW-1:0] BASE_B = 17'h01230;
  localparam logic [AW-1:0] ADR_C  = 17'h00040;
  localparam logic [AW-1:0] ADR_D  = 17'h00050;
  localparam logic [WW-1:0] V1     = 36'h9_1234_5678;
  localparam logic [WW-1:0] V2     = 36'hF_AABB_CCDD;
  localparam logic [WW-1:0] MERGED = 36'hB_AA34_CC78;
  localparam logic [WW-1:0] V3     = 36'h6_0F0F_A5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic wr_n = 1'b1, adv = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    bw_n = '1;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          rvalid;
  logic [WW-1:0] keep_d;
  logic          keep_v;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zt_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_n(wr_n), .adv(adv), .order_sel(order_sel), .addr(addr), .bw_n(bw_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [WW-1:0] mk(input logic [AW-1:0] a);
    return {a[3:0] ^ 4'h9, 8'h3C, a[7:0] ^ 8'h55, a[15:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    en_n = 1'b0; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1; adv = 1'b0; wr_n = 1'b1;
  endtask

  task automatic ld(input bit w, input logic [AW-1:0] a, input bit o, input logic [3:0] b);
    en_n = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; adv = 1'b0;
    wr_n = ~w; addr = a; order_sel = o; bw_n = b;
  endtask

  task automatic go();
    en_n = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; adv = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset, R11
    idle();
    repeat (3) tick();
    chk("R11 reset rvalid", {35'b0, rvalid}, '0);
    chk("R11 reset rdata", rdata, '0);
    rst_n = 1'b1;

    // fill four words of the burst block back to back, R8/R9 no turnaround
    for (int i = 0; i < 4; i++) begin
      ld(1'b1, BASE_B + AW'(i), 1'b0, 4'h0);
      wdata = (i == 0) ? '0 : mk(BASE_B + AW'(i - 1));
      tick();
    end
    idle();
    wdata = mk(BASE_B + 17'd3);
    tick();

    // table walk: R2 R3 R4 R5 R6
    for (int e = 0; e < 8; e++) begin
      logic        o;
      logic [1:0]  st;
      logic [7:0]  sq;
      {o, st, sq} = BURSTS[e];
      ld(1'b0, BASE_B | AW'(st), o, 4'hF);
      tick();
      for (int k = 1; k <= 7; k++) begin
        logic [1:0] lo;
        if (k < 7) begin
          go();
          order_sel = ~o;   // R6 ignored during advance
          wr_n = 1'b0;      // R6 ignored during advance
        end else begin
          idle();
        end
        tick();
        lo = sq[(3 - ((k - 1) % 4)) * 2 +: 2];
        chk(o ? "R4 R5 interleaved burst word" : "R3 R5 linear burst word", rdata, mk(BASE_B | AW'(lo)));
        chk("R7 burst rvalid", {35'b0, rvalid}, 36'd1);
      end
    end

    // R9 write then read same address on consecutive edges
    ld(1'b1, ADR_C, 1'b0, 4'h0); tick();
    ld(1'b0, ADR_C, 1'b0, 4'hF); wdata = V1; tick();
    idle(); tick();
    chk("R9 read after write", rdata, V1);
    chk("R9 rvalid", {35'b0, rvalid}, 36'd1);

    // R8 partial write: bytes 1 and 3 enabled
    ld(1'b1, ADR_C, 1'b0, 4'b0101); tick();
    idle(); wdata = V2; tick();
    chk("R7 rvalid low after write", {35'b0, rvalid}, '0);
    ld(1'b0, ADR_C, 1'b0, 4'hF); tick();
    idle(); tick();
    chk("R8 byte merge with parity", rdata, MERGED);

    // R1 each chip select alone blocks the access
    for (int j = 0; j < 3; j++) begin
      ld(1'b1, ADR_C, 1'b0, 4'h0);
      if (j == 0) sel1_n = 1'b1;
      if (j == 1) sel2 = 1'b0;
      if (j == 2) sel3_n = 1'b1;
      tick();
      idle(); wdata = 36'h0_DEAD_BEEF; tick();
      chk("R1 deselected rvalid", {35'b0, rvalid}, '0);
    end
    ld(1'b0, ADR_C, 1'b0, 4'hF); tick();
    idle(); tick();
    chk("R1 word unchanged by deselected writes", rdata, MERGED);

    // R10 pending write held across a stall
    ld(1'b1, ADR_C, 1'b0, 4'h0); tick();
    keep_d = rdata; keep_v = rvalid;
    en_n = 1'b1; wdata = 36'h1_1111_1111; tick();
    chk("R10 stall holds rdata", rdata, keep_d);
    chk("R10 stall holds rvalid", {35'b0, rvalid}, {35'b0, keep_v});
    idle(); wdata = V3; tick();
    ld(1'b0, ADR_C, 1'b0, 4'hF); tick();
    keep_d = rdata; keep_v = rvalid;
    ld(1'b1, ADR_D, 1'b0, 4'h0); en_n = 1'b1; tick();
    chk("R10 stalled read not yet out", rdata, keep_d);
    chk("R10 stalled rvalid held", {35'b0, rvalid}, {35'b0, keep_v});
    idle(); tick();
    chk("R10 delayed write data then read", rdata, V3);
    chk("R10 delayed read rvalid", {35'b0, rvalid}, 36'd1);

    // R10 R12 counter frozen by stall and by deselected advance
    ld(1'b0, BASE_B, 1'b0, 4'hF); tick();
    go(); tick();
    chk("R2 load word", rdata, mk(BASE_B));
    go(); en_n = 1'b1; tick();
    chk("R10 stall keeps output", rdata, mk(BASE_B));
    go(); sel2 = 1'b0; tick();
    chk("R3 second word", rdata, mk(BASE_B + 17'd1));
    go(); tick();
    chk("R1 deselected advance no read", {35'b0, rvalid}, '0);
    go(); tick();
    chk("R12 counter not moved by deselected advance", rdata, mk(BASE_B + 17'd2));
    idle(); tick();
    chk("R12 burst continues", rdata, mk(BASE_B + 17'd3));

    // R6 write burst, interleaved from start 1; advances carry wr_n high and order 0
    ld(1'b1, ADR_D | 17'd1, 1'b1, 4'h0); tick();
    go(); wr_n = 1'b1; order_sel = 1'b0; wdata = mk(ADR_D + 17'd16); tick();
    go(); wr_n = 1'b1; order_sel = 1'b0; wdata = mk(ADR_D + 17'd17); tick();
    idle(); wdata = mk(ADR_D + 17'd18); tick();
    ld(1'b0, ADR_D | 17'd3, 1'b0, 4'hF); tick();
    ld(1'b0, ADR_D, 1'b0, 4'hF); tick();
    chk("R6 R4 write burst third address", rdata, mk(ADR_D + 17'd18));
    ld(1'b0, ADR_D | 17'd1, 1'b0, 4'hF); tick();
    chk("R6 R4 write burst second address", rdata, mk(ADR_D + 17'd17));
    idle(); tick();
    chk("R6 R2 write burst first address", rdata, mk(ADR_D + 17'd16));

    // R11 reset mid run
    rst_n = 1'b0; tick();
    chk("R11 mid reset rdata", rdata, '0);
    chk("R11 mid reset rvalid", {35'b0, rvalid}, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule